// File: doc/BRIEF.md
# Tiled Surface Address Translator

This block maps a byte offset, as seen through a linear window onto a graphics surface, to the address where that byte really lives when the surface is stored as 4 KiB tiles. The requester supplies the linear offset, the surface pitch in bytes, a tiling layout code and a channel-swizzle code, all qualified by a valid strobe. One clock later the block returns the translated address together with two flags. One flag reports a pitch that the chosen layout cannot use. The other reports a memory-controller configuration under which tiling must not be done.

Two tiled layouts are supported: a wide one of 512-byte by 8-row tiles, and a tall one of 128-byte by 32-row tiles. Tiles are placed row-major across the surface. Within a tile, bytes are row-major. After the tile placement, address bit 6, which picks the memory channel, is rewritten by XOR with higher address bits so that vertically neighbouring rows alternate channels. A request can be accepted on every cycle.

Top module: `tiled_addr_xlat`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and requests may arrive on consecutive cycles.
- R2: Layout code 0 and code 3 mean linear: `rsp_addr` equals the request offset, and both flags are low whatever the pitch or swizzle code.
- R3: Layout code 1 (wide) uses tiles 512 bytes wide and 8 rows high, with one 4 KiB page per tile.
- R4: Layout code 2 (tall) uses tiles 128 bytes wide and 32 rows high, with one 4 KiB page per tile.
- R5: For a tiled layout with a legal pitch P and tile width W and height H, let row = off / P and col = off % P. Then the address is ((row/H)·(P/W) + col/W)·4096 + (row%H)·W + col%W, taken modulo 2^AW, before bit 6 is rewritten.
- R6: Swizzle code 0 leaves the tiled address unchanged.
- R7: Swizzle code 1 XORs bit 9 and bit 10 into bit 6 for the wide layout, and bit 9 alone for the tall layout. Bits 9, 10 and 6 are bits of the tiled address, and no other bit changes.
- R8: Swizzle code 2 does the same as code 1 and also XORs bit 11 into bit 6.
- R9: Swizzle code 3 with a tiled layout raises `rsp_unsupported`, keeps `rsp_pitch_err` low, and returns the offset unchanged.
- R10: With a tiled layout and a swizzle code other than 3, a pitch that is zero or is not a whole multiple of the tile width raises `rsp_pitch_err` and returns the offset unchanged.
- R11: In a cycle after one without a request, `rsp_addr` and both flags keep their previous values.
- R12: After reset, `rsp_valid`, `rsp_addr` and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe |
| req_lin_addr | input | AW | Linear byte offset |
| req_pitch | input | PW | Surface pitch in bytes |
| req_tile_mode | input | 2 | Layout: 0 linear, 1 wide tile, 2 tall tile, 3 linear |
| req_swz_mode | input | 2 | Swizzle: 0 off, 1 bits 9/10, 2 bits 9/10/11, 3 controller uses bit 17 |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_addr | output | AW | Translated address |
| rsp_pitch_err | output | 1 | Pitch illegal for the layout |
| rsp_unsupported | output | 1 | Tiling refused for this swizzle configuration |

## Verification
The bench uses the default widths, AW = 32 and PW = 16. With these, pitches up to 64 KiB and offsets across the whole 32-bit range are possible, so rows deep enough to reach bits 9, 10 and 11 of the tiled address are covered. So are pitches that are multiples of the tile width but not powers of two, and tile indices large enough to wrap past the top address bit. A behavioural model computes every expected result from integer division and remainder. The bench compares it with the outputs on every cycle, including idle cycles, where the held values are checked.

// File: rtl/tsat_pkg.sv
package tsat_pkg;
  // Layout codes on the request port
  typedef enum logic [1:0] {
    TM_LINEAR = 2'd0,
    TM_WIDE   = 2'd1,
    TM_TALL   = 2'd2,
    TM_LIN2   = 2'd3
  } tile_mode_e;

  // Channel swizzle codes on the request port
  typedef enum logic [1:0] {
    SW_OFF  = 2'd0,
    SW_BASE = 2'd1,
    SW_B11  = 2'd2,
    SW_B17  = 2'd3
  } swz_mode_e;

  localparam int unsigned PAGE_LOG   = 12;
  localparam int unsigned WIDE_WLOG  = 9;  // 512 bytes
  localparam int unsigned WIDE_HLOG  = 3;  // 8 rows
  localparam int unsigned TALL_WLOG  = 7;  // 128 bytes
  localparam int unsigned TALL_HLOG  = 5;  // 32 rows
  localparam int unsigned CHAN_BIT   = 6;
endpackage

// File: rtl/tsat_geom.sv
module tsat_geom
  import tsat_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned PW = 16
) (
  input  logic [AW-1:0] lin,
  input  logic [PW-1:0] pitch,
  input  tile_mode_e    mode,
  output logic [AW-1:0] tiled,
  output logic          pitch_bad
);
  logic [3:0]    wlog, hlog;
  logic [AW-1:0] pitch_ext, divisor, wmask, hmask;
  logic [AW-1:0] row, col, tpr, tile_idx;

  always_comb begin
    wlog      = (mode == TM_WIDE) ? 4'(WIDE_WLOG) : 4'(TALL_WLOG);
    hlog      = (mode == TM_WIDE) ? 4'(WIDE_HLOG) : 4'(TALL_HLOG);
    pitch_ext = {{(AW-PW){1'b0}}, pitch};
    wmask     = (AW'(1) << wlog) - AW'(1);
    hmask     = (AW'(1) << hlog) - AW'(1);
    pitch_bad = (pitch == '0) || ((pitch_ext & wmask) != '0);
    divisor   = pitch_bad ? AW'(1) : pitch_ext;
    row       = lin / divisor;
    col       = lin % divisor;
    tpr       = pitch_ext >> wlog;
    tile_idx  = (row >> hlog) * tpr + (col >> wlog);
    tiled     = (tile_idx << PAGE_LOG) | ((row & hmask) << wlog) | (col & wmask);
  end

  // R3/R4: a legal pitch always yields an offset inside the tile within the page
  always_comb begin
    p_intra_in_page_r5: assert (pitch_bad || mode == TM_LINEAR || mode == TM_LIN2 ||
                                (((row & hmask) << wlog) | (col & wmask)) < AW'(1 << PAGE_LOG))
      else $error("intra-tile offset leaves page");
  end
endmodule

// File: rtl/tsat_swz.sv
module tsat_swz
  import tsat_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] a_in,
  input  tile_mode_e    mode,
  input  swz_mode_e     swz,
  output logic [AW-1:0] a_out
);
  logic flip;

  always_comb begin
    flip = 1'b0;
    if (swz == SW_BASE || swz == SW_B11) begin
      flip = a_in[9] ^ ((mode == TM_WIDE) ? a_in[10] : 1'b0);
      if (swz == SW_B11) flip = flip ^ a_in[11];
    end
    a_out           = a_in;
    a_out[CHAN_BIT] = a_in[CHAN_BIT] ^ flip;
  end

  // R7: only the channel bit may differ
  always_comb begin
    p_only_chan_bit_r7: assert (((a_out ^ a_in) & ~(AW'(1) << CHAN_BIT)) == '0)
      else $error("swizzle touched a bit other than 6");
    // R6: swizzle off is the identity
    p_off_identity_r6: assert (swz != SW_OFF || a_out == a_in)
      else $error("swizzle off changed the address");
  end
endmodule

// File: rtl/tiled_addr_xlat.sv
module tiled_addr_xlat
  import tsat_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_lin_addr,
  input  logic [PW-1:0] req_pitch,
  input  logic [1:0]    req_tile_mode,
  input  logic [1:0]    req_swz_mode,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_addr,
  output logic          rsp_pitch_err,
  output logic          rsp_unsupported
);
  tile_mode_e    mode;
  swz_mode_e     swz;
  logic [1:0]    rst_sync_q;
  logic          srst_n;
  logic [AW-1:0] geom_addr, swz_addr;
  logic          geom_bad, is_tiled;
  logic [AW-1:0] addr_d;
  logic          perr_d, uns_d;

  assign mode = tile_mode_e'(req_tile_mode);
  assign swz  = swz_mode_e'(req_swz_mode);

  // Reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  tsat_geom #(.AW(AW), .PW(PW)) u_geom (
    .lin      (req_lin_addr),
    .pitch    (req_pitch),
    .mode     (mode),
    .tiled    (geom_addr),
    .pitch_bad(geom_bad)
  );

  tsat_swz #(.AW(AW)) u_swz (
    .a_in (geom_addr),
    .mode (mode),
    .swz  (swz),
    .a_out(swz_addr)
  );

  // Next-state
  always_comb begin
    is_tiled = (mode == TM_WIDE) || (mode == TM_TALL);
    uns_d    = is_tiled && (swz == SW_B17);
    perr_d   = is_tiled && !uns_d && geom_bad;
    addr_d   = (is_tiled && !uns_d && !geom_bad) ? swz_addr : req_lin_addr;
  end

  // Registers, data captured only when a request is present
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rsp_valid       <= 1'b0;
      rsp_addr        <= '0;
      rsp_pitch_err   <= 1'b0;
      rsp_unsupported <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_addr        <= addr_d;
        rsp_pitch_err   <= perr_d;
        rsp_unsupported <= uns_d;
      end
    end
  end

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!srst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!srst_n)
    !req_valid |=> !rsp_valid);
  p_linear_pass_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && (req_tile_mode == 2'd0 || req_tile_mode == 2'd3))
    |=> (rsp_addr == $past(req_lin_addr) && !rsp_pitch_err && !rsp_unsupported));
  p_refuse_pass_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && (req_tile_mode == 2'd1 || req_tile_mode == 2'd2) && req_swz_mode == 2'd3)
    |=> (rsp_unsupported && !rsp_pitch_err && rsp_addr == $past(req_lin_addr)));
  p_bad_pitch_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (req_valid && (req_tile_mode == 2'd1 || req_tile_mode == 2'd2) && req_swz_mode != 2'd3
     && (req_pitch[6:0] != 7'd0 || req_pitch == '0))
    |=> (rsp_pitch_err && !rsp_unsupported && rsp_addr == $past(req_lin_addr)));
  p_hold_r11: assert property (@(posedge clk) disable iff (!srst_n)
    !req_valid |=> ($stable(rsp_addr) && $stable(rsp_pitch_err) && $stable(rsp_unsupported)));
  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (!srst_n)
    !(rsp_pitch_err && rsp_unsupported));
endmodule

// File: tb/tiled_addr_xlat_bench.sv
`timescale 1ns/1ps
module tiled_addr_xlat_bench;
  localparam int unsigned AW = 32;
  localparam int unsigned PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_lin_addr = '0;
  logic [PW-1:0] req_pitch = '0;
  logic [1:0]    req_tile_mode = '0;
  logic [1:0]    req_swz_mode = '0;
  logic          rsp_valid, rsp_pitch_err, rsp_unsupported;
  logic [AW-1:0] rsp_addr;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  bit          exp_valid = 1'b0;
  logic [31:0] exp_addr = '0;
  bit          exp_perr = 1'b0;
  bit          exp_uns = 1'b0;
  string       exp_tag = "R12";

  always #2.5 clk = ~clk;

  tiled_addr_xlat #(.AW(AW), .PW(PW)) u_tiled_addr_xlat (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin_addr(req_lin_addr),
    .req_pitch(req_pitch), .req_tile_mode(req_tile_mode), .req_swz_mode(req_swz_mode),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_pitch_err(rsp_pitch_err),
    .rsp_unsupported(rsp_unsupported)
  );

  // Behavioural reference from the requirements
  task automatic model(input logic [31:0] a, input logic [15:0] p, input logic [1:0] tm,
                       input logic [1:0] sm, output logic [31:0] ra, output bit perr, output bit uns);
    longint unsigned tw, th, row, col, t;
    logic [31:0] t32;
    bit flip;
    perr = 0; uns = 0; ra = a;
    if (tm == 2'd1 || tm == 2'd2) begin
      tw = (tm == 2'd1) ? 512 : 128;
      th = (tm == 2'd1) ? 8 : 32;
      if (sm == 2'd3) uns = 1;
      else if (p == 0 || (p % tw) != 0) perr = 1;
      else begin
        row = a / p; col = a % p;
        t = ((row / th) * (p / tw) + col / tw) * 4096 + (row % th) * tw + col % tw;
        t32 = t[31:0];
        flip = 0;
        if (sm != 2'd0) begin
          flip = t32[9] ^ ((tm == 2'd1) ? t32[10] : 1'b0);
          if (sm == 2'd2) flip = flip ^ t32[11];
        end
        t32[6] = t32[6] ^ flip;
        ra = t32;
      end
    end
  endtask

  task automatic check_out();
    n_checks++;
    if (rsp_valid !== exp_valid || rsp_addr !== exp_addr ||
        rsp_pitch_err !== exp_perr || rsp_unsupported !== exp_uns) begin
      n_errors++;
      $display("FAIL %s: got v=%0b a=%h perr=%0b uns=%0b expected v=%0b a=%h perr=%0b uns=%0b",
               exp_tag, rsp_valid, rsp_addr, rsp_pitch_err, rsp_unsupported,
               exp_valid, exp_addr, exp_perr, exp_uns);
    end
  endtask

  // One cycle: check the previous cycle's result, then drive the next request
  task automatic step(input bit v, input logic [31:0] a, input logic [15:0] p,
                      input logic [1:0] tm, input logic [1:0] sm, input string tag);
    logic [31:0] ra;
    bit pe, un;
    @(negedge clk);
    check_out();
    req_valid = v; req_lin_addr = a; req_pitch = p; req_tile_mode = tm; req_swz_mode = sm;
    exp_valid = v;
    if (v) begin
      model(a, p, tm, sm, ra, pe, un);
      exp_addr = ra; exp_perr = pe; exp_uns = un; exp_tag = tag;
    end else exp_tag = (tag == "") ? "R11" : tag;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R12: reset state (expected all zero)
    @(negedge clk);
    exp_tag = "R12";
    check_out();

    // R2: linear codes 0 and 3
    step(1, 32'h1234_5678, 16'd2048, 2'd0, 2'd1, "R2");
    step(1, 32'hDEAD_BEEF, 16'd1000, 2'd3, 2'd3, "R2");
    // R3: wide tiles, swizzle off
    step(1, 32'd0,          16'd2048, 2'd1, 2'd0, "R3");
    step(1, 32'd2052,       16'd2048, 2'd1, 2'd0, "R3");
    step(1, 32'd700,        16'd2048, 2'd1, 2'd0, "R3");
    step(1, 32'd16384,      16'd2048, 2'd1, 2'd0, "R3");
    // R4: tall tiles, including a pitch legal only for tall
    step(1, 32'd15999,      16'd512,  2'd2, 2'd0, "R4");
    step(1, 32'd16384,      16'd512,  2'd2, 2'd0, "R4");
    step(1, 32'd129,        16'd512,  2'd2, 2'd0, "R4");
    step(1, 32'd6500,       16'd640,  2'd2, 2'd0, "R4");
    // R5: non power-of-two pitch and wrap past the top bit
    step(1, 32'd123_457,    16'd1536, 2'd1, 2'd0, "R5");
    step(1, 32'hFFFF_FF00,  16'd65024, 2'd1, 2'd0, "R5");
    // R6/R7/R8: channel swizzle
    step(1, 32'd8192,       16'd4096, 2'd1, 2'd0, "R6");
    step(1, 32'd8192,       16'd4096, 2'd1, 2'd1, "R7");
    step(1, 32'd12352,      16'd4096, 2'd1, 2'd1, "R7");
    step(1, 32'd3584,       16'd512,  2'd2, 2'd1, "R7");
    step(1, 32'd2560,       16'd512,  2'd2, 2'd2, "R8");
    step(1, 32'd24576,      16'd4096, 2'd1, 2'd2, "R8");
    // R9: controller swizzles on bit 17
    step(1, 32'd24576,      16'd4096, 2'd1, 2'd3, "R9");
    step(1, 32'd777,        16'd512,  2'd2, 2'd3, "R9");
    // R10: illegal pitch
    step(1, 32'd5000,       16'd1000, 2'd1, 2'd1, "R10");
    step(1, 32'd5000,       16'd0,    2'd2, 2'd0, "R10");
    step(1, 32'd5000,       16'd640,  2'd1, 2'd2, "R10");
    step(1, 32'd5000,       16'd100,  2'd2, 2'd1, "R10");
    // R11: idle cycles hold the last result
    step(0, 32'hFFFF_FFFF,  16'd512,  2'd1, 2'd1, "R11");
    step(0, 32'h0000_1000,  16'd3,    2'd2, 2'd3, "R11");
    // R1: back-to-back and bubbled mixed traffic
    for (int i = 0; i < 400; i++) begin
      bit v;
      logic [1:0] tm, sm;
      logic [15:0] p;
      int unsigned k;
      v  = ($urandom % 5) != 0;
      tm = 2'($urandom);
      sm = 2'($urandom);
      k  = 1 + ($urandom % 60);
      p  = 16'((tm == 2'd1) ? k * 512 : k * 128);
      if (($urandom % 8) == 0) p = 16'($urandom);
      step(v, $urandom, p, tm, sm, v ? "R1" : "R11");
    end
    step(0, 32'd0, 16'd0, 2'd0, 2'd0, "R1");
    @(negedge clk);
    check_out();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule